// File: doc/BRIEF.md
# Windowed Backplane Address Mapper

This block sits on the card side of a narrow host link and lets the host reach a 32-bit internal backplane through a small memory window. Software programs the window base through a byte-wide configuration port. Three byte registers together hold backplane address bits 31:12. A one-bit segment register picks which 2 KB half of the selected core's window the host offset lands in. Every register reads back what was stored, so software can confirm that a switch took effect before it uses the window.

Each host access is 8 or 16 bits wide and carries an 11-bit window offset. The block joins the stored window fields, the segment bit and the offset into one backplane address. It then runs a request/acknowledge transaction on a 16-bit backplane bus and stalls the host with a wait signal until the response comes back. A 32-bit quantity travels as two 16-bit accesses: the low half at the offset, then the high half at the offset plus 2. The window and the access attributes are captured when the access is accepted. A configuration write made while the access is still outstanding therefore cannot move that access.

Top module: `bp_window_mapper`

## Requirements
- R1: After a synchronous active-low reset, every configuration register reads 0x00, `bp_req` is low, and `host_wait` is low while `host_req` is low.
- R2: Configuration offset 0x2E stores bits 3:0 of a write as backplane address bits 15:12. Reading it returns that nibble in bits 3:0 with bits 7:4 as zero.
- R3: Offsets 0x30 and 0x32 store full bytes for address bits 23:16 and 31:24 respectively, and each reads back the whole byte last written.
- R4: Offset 0x34 is the segment register. A write of 0x00 or 0x01 is stored and read back. A write of any other value is ignored, so the previous segment is kept.
- R5: A configuration offset other than 0x2E, 0x30, 0x32 and 0x34 reads as 0x00, and a write to it changes no register.
- R6: The backplane address is {reg 0x32, reg 0x30, reg 0x2E[3:0], segment, offset[10:0]}. For a 16-bit access, offset bit 0 is forced to 0, so a segment of 1 adds 0x800 to the host offset.
- R7: Byte lanes: a 16-bit access drives `bp_be`=2'b11. A byte access drives 2'b01 when offset bit 0 is 0 and 2'b10 when it is 1. A byte write places `host_wdata[7:0]` on both halves of `bp_wdata`, and a 16-bit write passes `host_wdata` through unchanged.
- R8: The handshake works as follows. An access accepted at one clock edge raises `bp_req` after that edge. `bp_req` stays high until the edge at which `bp_ack` is sampled high. `host_wait` is high from the request until that edge and low for the one cycle that follows. With an acknowledge delay of D cycles, the access takes 3+D edges.
- R9: Read data is handled as follows. A 16-bit read returns `bp_rdata` unchanged. A byte read returns the selected lane in bits 7:0 with bits 15:8 as zero.
- R10: The address, byte enables and write data of an outstanding backplane request stay constant until it is acknowledged, even if the window registers are rewritten meanwhile. The next access uses the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the register at `cfg_addr` |
| host_req | input | 1 | Host window access request, held until `host_wait` is low |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_off | input | 11 | Offset within the window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid while `host_wait` is low after a read |
| host_wait | output | 1 | Stall to the host |
| bp_req | output | 1 | Backplane request |
| bp_wr | output | 1 | Backplane write |
| bp_addr | output | 32 | Backplane address |
| bp_be | output | 2 | Backplane byte enables |
| bp_wdata | output | 16 | Backplane write data |
| bp_ack | input | 1 | Backplane response valid |
| bp_rdata | input | 16 | Backplane read data |

## Verification
The hardest case to reach from the ports is a window register rewritten while a backplane request is still outstanding. The bench reaches it by stretching the acknowledge delay of its backplane model to several cycles. While the host is still stalled, it writes a new value to the 0x30 register. It then checks that the acknowledged address still carries the old window and that the following access carries the new one. Illegal segment writes and writes to undecoded offsets are both checked in the same way. Each is followed by a register readback and by a real access whose address shows whether the segment or a window byte moved.

// File: rtl/bpw_pkg.sv
// Shared constants and types for the windowed backplane address mapper.
package bpw_pkg;
    localparam int WIN_BYTE_W = 8;   // width of the two full-byte window registers
    localparam int WIN_NIB_W  = 4;   // width of the low window field (bits 15:12)

    // Configuration register offsets (software-visible, fixed by the host driver)
    localparam int OFS_WIN_LO  = 'h2E;
    localparam int OFS_WIN_MID = 'h30;
    localparam int OFS_WIN_HI  = 'h32;
    localparam int OFS_SEG     = 'h34;

    // Stored window: the upper bits of every backplane address
    typedef struct packed {
        logic [WIN_BYTE_W-1:0] hi;
        logic [WIN_BYTE_W-1:0] mid;
        logic [WIN_NIB_W-1:0]  lo;
        logic                  seg;
    } window_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_BUSY = 2'd1,
        XS_DONE = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/bpw_cfg_regs.sv
// Configuration register file: the three window registers and the segment
// select, with byte-wide writes and combinational readback.
// Assumes: cfg_addr and cfg_wdata are valid whenever cfg_wr is high.
module bpw_cfg_regs
    import bpw_pkg::*;
#(
    parameter int CFG_AW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [WIN_BYTE_W-1:0] cfg_wdata,
    output logic [WIN_BYTE_W-1:0] cfg_rdata,
    output window_t               win
);
    localparam int CFG_DW = WIN_BYTE_W;
    localparam logic [CFG_AW-1:0] A_LO  = CFG_AW'(OFS_WIN_LO);
    localparam logic [CFG_AW-1:0] A_MID = CFG_AW'(OFS_WIN_MID);
    localparam logic [CFG_AW-1:0] A_HI  = CFG_AW'(OFS_WIN_HI);
    localparam logic [CFG_AW-1:0] A_SEG = CFG_AW'(OFS_SEG);

    logic seg_legal;
    logic addr_hit;

    // Segment writes are accepted only for the values 0 and 1
    assign seg_legal = (cfg_wdata[CFG_DW-1:1] == '0);
    assign addr_hit  = (cfg_addr == A_LO) || (cfg_addr == A_MID) ||
                       (cfg_addr == A_HI) || (cfg_addr == A_SEG);

    // Register update on configuration writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (cfg_wr) begin
            case (cfg_addr)
                A_LO:    win.lo  <= cfg_wdata[WIN_NIB_W-1:0];
                A_MID:   win.mid <= cfg_wdata;
                A_HI:    win.hi  <= cfg_wdata;
                A_SEG:   if (seg_legal) win.seg <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    // Readback mux; undecoded offsets read as zero
    always_comb begin
        case (cfg_addr)
            A_LO:    cfg_rdata = {{(CFG_DW-WIN_NIB_W){1'b0}}, win.lo};
            A_MID:   cfg_rdata = win.mid;
            A_HI:    cfg_rdata = win.hi;
            A_SEG:   cfg_rdata = {{(CFG_DW-1){1'b0}}, win.seg};
            default: cfg_rdata = '0;
        endcase
    end

    assert_lo_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == A_LO) |=> (win.lo == $past(cfg_wdata[WIN_NIB_W-1:0])));
    assert_seg_illegal_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == A_SEG && !seg_legal) |=> $stable(win.seg));
    assert_undecoded_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !addr_hit) |=> $stable(win));
endmodule

// File: rtl/bpw_addr_compose.sv
// Address composer: joins the stored window, the segment bit and the host
// offset into a backplane address and derives the byte enables.
// Assumes: 16-bit accesses are half-word aligned (bit 0 is dropped).
module bpw_addr_compose
    import bpw_pkg::*;
#(
    parameter int BP_AW = 32,
    localparam int OFF_W = BP_AW - $bits(window_t)
) (
    input  window_t          win,
    input  logic [OFF_W-1:0] host_off,
    input  logic             host_wide,
    output logic [BP_AW-1:0] addr,
    output logic [1:0]       be
);
    logic [OFF_W-1:0] off_al;

    // Align wide accesses, pick the byte lane for narrow ones
    always_comb begin
        off_al = host_off;
        if (host_wide) begin
            off_al[0] = 1'b0;
            be        = 2'b11;
        end else begin
            be        = host_off[0] ? 2'b10 : 2'b01;
        end
        addr = {win.hi, win.mid, win.lo, win.seg, off_al};
    end
endmodule

// File: rtl/bpw_bus_ctrl.sv
// Backplane bus controller: accepts a host access, holds its attributes in
// a transaction latch, runs one req/ack exchange and returns read data.
// Assumes: the host holds host_req and its attributes until host_wait is
// low, and drops host_req in the cycle where host_wait is low.
module bpw_bus_ctrl
    import bpw_pkg::*;
#(
    parameter int BP_AW = 32,
    parameter int BP_DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             host_wide,
    input  logic [BP_DW-1:0] host_wdata,
    input  logic [BP_AW-1:0] comp_addr,
    input  logic [1:0]       comp_be,
    output logic [BP_DW-1:0] host_rdata,
    output logic             host_wait,
    output logic             bp_req,
    output logic             bp_wr,
    output logic [BP_AW-1:0] bp_addr,
    output logic [1:0]       bp_be,
    output logic [BP_DW-1:0] bp_wdata,
    input  logic             bp_ack,
    input  logic [BP_DW-1:0] bp_rdata
);
    localparam int HALF = BP_DW / 2;

    xfer_state_e state;
    logic        wide_q;

    // Transfer sequencing: idle -> busy (request out) -> done (host released)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XS_IDLE;
        end else begin
            case (state)
                XS_IDLE: if (host_req) state <= XS_BUSY;
                XS_BUSY: if (bp_ack)   state <= XS_DONE;
                default:               state <= XS_IDLE;
            endcase
        end
    end

    // Transaction latch: capture address, lanes and data at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_addr  <= '0;
            bp_be    <= '0;
            bp_wr    <= 1'b0;
            bp_wdata <= '0;
            wide_q   <= 1'b0;
        end else if (state == XS_IDLE && host_req) begin
            bp_addr  <= comp_addr;
            bp_be    <= comp_be;
            bp_wr    <= host_wr;
            bp_wdata <= host_wide ? host_wdata : {2{host_wdata[HALF-1:0]}};
            wide_q   <= host_wide;
        end
    end

    // Read-data return: lane select for byte reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (state == XS_BUSY && bp_ack) begin
            if (wide_q)        host_rdata <= bp_rdata;
            else if (bp_be[1]) host_rdata <= {{HALF{1'b0}}, bp_rdata[BP_DW-1:HALF]};
            else               host_rdata <= {{HALF{1'b0}}, bp_rdata[HALF-1:0]};
        end
    end

    assign bp_req    = (state == XS_BUSY);
    assign host_wait = host_req && (state != XS_DONE);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && !bp_ack) |=> bp_req);
    assert_wait_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && bp_ack) |=> (!host_wait && !bp_req));
    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && !bp_ack) |=> ($stable(bp_addr) && $stable(bp_be) && $stable(bp_wdata)));
    assert_lanes_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bp_req |-> ($countones(bp_be) == 2 || $onehot0(bp_be) && bp_be != 2'b00));
endmodule

// File: rtl/bp_window_mapper.sv
// Top level of the windowed backplane address mapper: configuration
// registers, address composer and backplane bus controller.
// Assumes: a single clock domain shared by host and backplane sides.
module bp_window_mapper
    import bpw_pkg::*;
#(
    parameter int CFG_AW = 8,
    parameter int BP_AW  = 32,
    parameter int BP_DW  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [CFG_AW-1:0]                cfg_addr,
    input  logic [WIN_BYTE_W-1:0]            cfg_wdata,
    output logic [WIN_BYTE_W-1:0]            cfg_rdata,
    input  logic                             host_req,
    input  logic                             host_wr,
    input  logic                             host_wide,
    input  logic [BP_AW-$bits(window_t)-1:0] host_off,
    input  logic [BP_DW-1:0]                 host_wdata,
    output logic [BP_DW-1:0]                 host_rdata,
    output logic                             host_wait,
    output logic                             bp_req,
    output logic                             bp_wr,
    output logic [BP_AW-1:0]                 bp_addr,
    output logic [1:0]                       bp_be,
    output logic [BP_DW-1:0]                 bp_wdata,
    input  logic                             bp_ack,
    input  logic [BP_DW-1:0]                 bp_rdata
);
    window_t          win;
    logic [BP_AW-1:0] comp_addr;
    logic [1:0]       comp_be;

    bpw_cfg_regs #(.CFG_AW(CFG_AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .win       (win)
    );

    bpw_addr_compose #(.BP_AW(BP_AW)) u_comp (
        .win       (win),
        .host_off  (host_off),
        .host_wide (host_wide),
        .addr      (comp_addr),
        .be        (comp_be)
    );

    bpw_bus_ctrl #(.BP_AW(BP_AW), .BP_DW(BP_DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_wide  (host_wide),
        .host_wdata (host_wdata),
        .comp_addr  (comp_addr),
        .comp_be    (comp_be),
        .host_rdata (host_rdata),
        .host_wait  (host_wait),
        .bp_req     (bp_req),
        .bp_wr      (bp_wr),
        .bp_addr    (bp_addr),
        .bp_be      (bp_be),
        .bp_wdata   (bp_wdata),
        .bp_ack     (bp_ack),
        .bp_rdata   (bp_rdata)
    );
endmodule

// File: tb/bp_window_mapper_bench.sv
module bp_window_mapper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    typedef struct packed {
        logic [3:0]  nib;
        logic [7:0]  mid;
        logic [7:0]  hi;
        logic        seg;
        logic [10:0] off;
        logic        wide;
        logic        wr;
        logic [15:0] wdata;
        logic [31:0] exp_addr;
        logic [1:0]  exp_be;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{4'h1, 8'h00, 8'h18, 1'b0, 11'h004, 1'b1, 1'b0, 16'h0000, 32'h18001004, 2'b11},
        '{4'h2, 8'h00, 8'h18, 1'b1, 11'h010, 1'b1, 1'b0, 16'h0000, 32'h18002810, 2'b11},
        '{4'hF, 8'hAB, 8'hCD, 1'b0, 11'h7FF, 1'b0, 1'b0, 16'h0000, 32'hCDABF7FF, 2'b10},
        '{4'h5, 8'h12, 8'h34, 1'b1, 11'h3FE, 1'b0, 1'b1, 16'h0077, 32'h34125BFE, 2'b01},
        '{4'h0, 8'h00, 8'h00, 1'b0, 11'h001, 1'b1, 1'b1, 16'hBEEF, 32'h00000000, 2'b11},
        '{4'hA, 8'h55, 8'hFF, 1'b1, 11'h7FF, 1'b1, 1'b0, 16'h0000, 32'hFF55AFFE, 2'b11},
        '{4'h3, 8'h01, 8'h02, 1'b0, 11'h100, 1'b1, 1'b0, 16'h0000, 32'h02013100, 2'b11},
        '{4'h3, 8'h01, 8'h02, 1'b0, 11'h102, 1'b1, 1'b0, 16'h0000, 32'h02013102, 2'b11}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_wide = 1'b0;
    logic [10:0] host_off = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_wait;
    logic        bp_req;
    logic        bp_wr;
    logic [31:0] bp_addr;
    logic [1:0]  bp_be;
    logic [15:0] bp_wdata;
    logic        bp_ack = 1'b0;
    logic [15:0] bp_rdata = '0;

    int checks = 0;
    int errors = 0;
    int ack_delay = 0;
    int ack_cnt = 0;
    logic [31:0] cap_addr;
    logic [1:0]  cap_be;
    logic        cap_wr;
    logic [15:0] cap_wdata;
    int          acc_edges;
    int          acc_req_cycles;
    logic [15:0] acc_rdata;

    bp_window_mapper u_bp_window_mapper (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_req(host_req), .host_wr(host_wr), .host_wide(host_wide), .host_off(host_off),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wait(host_wait),
        .bp_req(bp_req), .bp_wr(bp_wr), .bp_addr(bp_addr), .bp_be(bp_be),
        .bp_wdata(bp_wdata), .bp_ack(bp_ack), .bp_rdata(bp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Backplane model: acknowledges after ack_delay extra cycles
    always @(posedge clk) begin
        if (bp_ack) begin
            bp_ack <= 1'b0;
        end else if (bp_req) begin
            if (ack_cnt >= ack_delay) begin
                bp_ack    <= 1'b1;
                bp_rdata  <= bp_addr[15:0] ^ 16'h5A3C;
                cap_addr  <= bp_addr;
                cap_be    <= bp_be;
                cap_wr    <= bp_wr;
                cap_wdata <= bp_wdata;
                ack_cnt   <= 0;
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYCLES);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // One host access; records edges to release, request cycles and read data
    task automatic access(input logic wr, input logic wide, input logic [10:0] off,
                          input logic [15:0] wd);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_wide = wide; host_off = off; host_wdata = wd;
        acc_edges = 0; acc_req_cycles = 0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            acc_edges++;
            if (bp_req) acc_req_cycles++;
            if (!host_wait) break;
        end
        acc_rdata = host_rdata;
        @(negedge clk);
        host_req = 1'b0;
    endtask

    function automatic logic [15:0] exp_read(input logic [31:0] a, input logic wide,
                                             input logic [1:0] be);
        logic [15:0] r;
        r = a[15:0] ^ 16'h5A3C;
        if (wide) return r;
        return be[1] ? {8'h00, r[15:8]} : {8'h00, r[7:0]};
    endfunction

    function automatic logic [15:0] exp_wdata(input logic wide, input logic [15:0] d);
        return wide ? d : {d[7:0], d[7:0]};
    endfunction

    logic [7:0] rd;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cfg_read(8'h2E, rd); check("R1 reg 0x2E", rd, 0);
        cfg_read(8'h30, rd); check("R1 reg 0x30", rd, 0);
        cfg_read(8'h32, rd); check("R1 reg 0x32", rd, 0);
        cfg_read(8'h34, rd); check("R1 reg 0x34", rd, 0);
        check("R1 bp_req", bp_req, 0);
        check("R1 host_wait", host_wait, 0);

        // Table walk: program window, read it back, run the access
        for (int v = 0; v < NVEC; v++) begin
            cfg_write(8'h2E, {4'h0, VEC[v].nib});
            cfg_write(8'h30, VEC[v].mid);
            cfg_write(8'h32, VEC[v].hi);
            cfg_write(8'h34, {7'h0, VEC[v].seg});
            cfg_read(8'h2E, rd); check("R2 nibble readback", rd, {4'h0, VEC[v].nib});
            cfg_read(8'h30, rd); check("R3 mid readback", rd, VEC[v].mid);
            cfg_read(8'h32, rd); check("R3 hi readback", rd, VEC[v].hi);
            cfg_read(8'h34, rd); check("R4 seg readback", rd, {7'h0, VEC[v].seg});
            access(VEC[v].wr, VEC[v].wide, VEC[v].off, VEC[v].wdata);
            check("R6 bp_addr", cap_addr, VEC[v].exp_addr);
            check("R7 bp_be", cap_be, VEC[v].exp_be);
            check("R8 bp_wr", cap_wr, VEC[v].wr);
            if (VEC[v].wr)
                check("R7 bp_wdata", cap_wdata, exp_wdata(VEC[v].wide, VEC[v].wdata));
            else
                check("R9 host_rdata", acc_rdata,
                      exp_read(VEC[v].exp_addr, VEC[v].wide, VEC[v].exp_be));
        end

        // R2: upper nibble of a write to 0x2E is dropped
        cfg_write(8'h2E, 8'hF7);
        cfg_read(8'h2E, rd); check("R2 upper nibble dropped", rd, 8'h07);

        // R4: illegal segment value ignored; seen by readback and by an access
        cfg_write(8'h30, 8'h00);
        cfg_write(8'h32, 8'h00);
        cfg_write(8'h34, 8'h01);
        cfg_write(8'h34, 8'h02);
        cfg_read(8'h34, rd); check("R4 illegal 0x02 kept seg", rd, 8'h01);
        cfg_write(8'h34, 8'h00);
        cfg_write(8'h34, 8'hFF);
        cfg_read(8'h34, rd); check("R4 illegal 0xFF kept seg", rd, 8'h00);
        access(1'b0, 1'b1, 11'h020, 16'h0);
        check("R4 seg after illegal write", cap_addr, 32'h00007020);

        // R5: undecoded offsets read zero and leave registers alone
        cfg_write(8'h30, 8'h66);
        cfg_write(8'h31, 8'hFF);
        cfg_write(8'h40, 8'hFF);
        cfg_write(8'h2F, 8'hFF);
        cfg_read(8'h31, rd); check("R5 0x31 reads zero", rd, 0);
        cfg_read(8'h40, rd); check("R5 0x40 reads zero", rd, 0);
        cfg_read(8'h30, rd); check("R5 0x30 unchanged", rd, 8'h66);
        cfg_read(8'h2E, rd); check("R5 0x2E unchanged", rd, 8'h07);
        access(1'b0, 1'b0, 11'h001, 16'h0);
        check("R5 window unchanged in address", cap_addr, 32'h00667001);

        // R8: handshake timing with and without acknowledge delay
        ack_delay = 0;
        access(1'b0, 1'b1, 11'h000, 16'h0);
        check("R8 edges delay 0", acc_edges, 3);
        check("R8 req cycles delay 0", acc_req_cycles, 2);
        ack_delay = 4;
        access(1'b1, 1'b1, 11'h002, 16'h1234);
        check("R8 edges delay 4", acc_edges, 7);
        check("R8 req cycles delay 4", acc_req_cycles, 6);
        check("R8 bp_req low after", bp_req, 0);

        // R10: window rewrite while a request is outstanding
        ack_delay = 5;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_wide = 1'b1; host_off = 11'h040;
        @(negedge clk);
        check("R10 wait during request", host_wait, 1);
        cfg_wr = 1'b1; cfg_addr = 8'h30; cfg_wdata = 8'h99;
        @(negedge clk);
        cfg_wr = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(posedge clk); #1;
            if (!host_wait) break;
        end
        @(negedge clk);
        host_req = 1'b0;
        check("R10 in-flight address kept", cap_addr, 32'h00667040);
        ack_delay = 0;
        access(1'b0, 1'b1, 11'h040, 16'h0);
        check("R10 next access uses new window", cap_addr, 32'h00997040);

        // R1: reset returns registers to zero
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        cfg_read(8'h30, rd); check("R1 reset clears 0x30", rd, 0);
        cfg_read(8'h2E, rd); check("R1 reset clears 0x2E", rd, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule